// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank with Overflow Carry

This block keeps the frame, byte and error tallies of an Ethernet MAC. The receive and transmit paths classify each frame elsewhere and send a one-cycle event pulse per counter. A pulse on a byte counter adds the frame length; a pulse on any other counter adds one. Two event groups exist. The receive group includes the frame-size buckets, and it reports into one carry register. The transmit group reports into the other.

Each counter is a plain wrapping accumulator. When a counter wraps, a sticky carry bit records the overflow. Software reads the carry bits and clears them by writing ones. Two mask registers decide which carry bits may reach the overflow interrupt, and a separate interrupt enable gates that interrupt as a whole. A control word holds the global counting enable and a self-clearing command that zeroes every counter and every carry bit at once. All registers sit behind a 32-bit word-addressed port. Writes take effect at the clock edge, and reads are combinational from the address.

Top module: `stats_bank`

## Requirements
- R1: Carry register addresses: receive group at word 2, transmit group at word 3. Each bit stays set until cleared. Writing a one to a bit clears that bit, and writing a zero leaves it unchanged.
- R2: Mask registers: receive at word 4, transmit at word 5. Both reset to all ones. A mask bit at one keeps the matching carry bit from the interrupt.
- R3: Control word 0, bit 0 is the counting enable. While it is zero, no counter changes on any event.
- R4: Writing a one to control bit 1 zeroes every counter and both carry registers at the next clock edge. The bit reads as one for exactly that one cycle and then returns to zero on its own.
- R5: Word 1, bit 0 is the interrupt enable. While it is zero, `ovf_irq` is low.
- R6: `ovf_irq` is high when the interrupt enable is set and at least one carry bit is set with its mask bit clear.
- R7: Counter reads: receive counter i at word 16+i, then transmit counter j at word 16+NUM_RX_CNT+j. An event adds one to its counter. The receive byte counter (index RX_BYTE_IDX) adds `rx_len` instead, and the transmit byte counter (index TX_BYTE_IDX) adds `tx_len` instead. A counter that passes its maximum wraps modulo 2^CNT_W and sets carry bit i of its group.
- R8: If an event and the clear command's effect fall in the same cycle, the counter ends at zero.
- R9: If a carry bit is set by a wrap in the same cycle that software writes one to it, the bit stays set.
- R10: After reset, the counters, control word, interrupt enable and carry registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Word address of register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| rx_evt | input | NUM_RX_CNT | Receive-group event pulses, one per counter |
| rx_len | input | LEN_W | Frame length added by the receive byte counter |
| tx_evt | input | NUM_TX_CNT | Transmit-group event pulses, one per counter |
| tx_len | input | LEN_W | Frame length added by the transmit byte counter |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
The assertions that clear-all leaves only zeroed state depend on one property of the inputs: a single frame length must not reach 2^CNT_W, so a counter that starts at zero cannot wrap on its first event. The bench keeps to this. It shrinks CNT_W to 12 and LEN_W to 8, which also lets wraps occur within a few thousand cycles. Events and register writes change only at falling edges, as single-cycle pulses. The carry-stickiness assertion is conditioned on there being no carry write and no clear, so the bench may mix those freely.

// File: rtl/stats_pkg.sv
package stats_pkg;
  localparam int REG_CTRL     = 0;
  localparam int REG_IRQ      = 1;
  localparam int REG_CARRY_RX = 2;
  localparam int REG_CARRY_TX = 3;
  localparam int REG_MASK_RX  = 4;
  localparam int REG_MASK_TX  = 5;
  localparam int CNT_BASE     = 16;

  // Adds inc to cur inside a width-bit accumulator.
  // Bit 32 of the result is the carry out of that width.
  function automatic logic [32:0] acc_add(logic [31:0] cur, logic [31:0] inc,
                                          int unsigned width);
    logic [32:0] s;
    logic [32:0] keep;
    s    = {1'b0, cur} + {1'b0, inc};
    keep = (33'd1 << width) - 33'd1;
    return {s[width], 32'(s & keep)};
  endfunction
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             evt,
  input  logic [31:0]      inc,
  output logic [CNT_W-1:0] value,
  output logic             wrap
);
  logic        bump;
  logic [32:0] step;

  assign bump = evt & en;

  always_comb step = stats_pkg::acc_add(32'(value), inc, CNT_W);

  assign wrap = bump & step[32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     value <= '0;
    else if (clr)   value <= '0;
    else if (bump)  value <= step[CNT_W-1:0];
  end
endmodule

// File: rtl/carry_bank.sv
module carry_bank #(
  parameter int N = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  input  logic         w1c_en,
  input  logic         mask_wr,
  input  logic [31:0]  wdata,
  output logic [31:0]  carry,
  output logic [31:0]  mask,
  output logic         pend
);
  logic [31:0] set_pad;
  logic [31:0] drop;

  assign set_pad = 32'(set);
  assign drop    = w1c_en ? wdata : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry <= '0;
      mask  <= '1;
    end else begin
      if (mask_wr) mask <= wdata;
      if (clr) carry <= '0;
      else     carry <= (carry & ~drop) | set_pad;
    end
  end

  assign pend = |(carry & ~mask);
endmodule

// File: rtl/stats_bank.sv
module stats_bank #(
  parameter int NUM_RX_CNT  = 21,
  parameter int NUM_TX_CNT  = 8,
  parameter int CNT_W       = 32,
  parameter int LEN_W       = 16,
  parameter int RX_BYTE_IDX = 7,
  parameter int TX_BYTE_IDX = 0,
  parameter int ADDR_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_wr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NUM_RX_CNT-1:0] rx_evt,
  input  logic [LEN_W-1:0]      rx_len,
  input  logic [NUM_TX_CNT-1:0] tx_evt,
  input  logic [LEN_W-1:0]      tx_len,
  output logic                  ovf_irq
);
  import stats_pkg::*;

  localparam int NUM_CNT = NUM_RX_CNT + NUM_TX_CNT;

  logic stat_en, irq_en, clr_fire;
  logic wr_ctrl, ctrl_clr_wr, wr_irq;
  logic wr_carry_rx, wr_carry_tx, wr_mask_rx, wr_mask_tx;
  logic [NUM_RX_CNT-1:0] rx_wrap;
  logic [NUM_TX_CNT-1:0] tx_wrap;
  logic [CNT_W-1:0] rx_val [NUM_RX_CNT];
  logic [CNT_W-1:0] tx_val [NUM_TX_CNT];
  logic [NUM_CNT*CNT_W-1:0] all_cnt;
  logic [31:0] carry_rx, carry_tx, mask_rx, mask_tx;
  logic pend_rx, pend_tx;

  assign wr_ctrl     = reg_wr && (reg_addr == ADDR_W'(REG_CTRL));
  assign ctrl_clr_wr = wr_ctrl && reg_wdata[1];
  assign wr_irq      = reg_wr && (reg_addr == ADDR_W'(REG_IRQ));
  assign wr_carry_rx = reg_wr && (reg_addr == ADDR_W'(REG_CARRY_RX));
  assign wr_carry_tx = reg_wr && (reg_addr == ADDR_W'(REG_CARRY_TX));
  assign wr_mask_rx  = reg_wr && (reg_addr == ADDR_W'(REG_MASK_RX));
  assign wr_mask_tx  = reg_wr && (reg_addr == ADDR_W'(REG_MASK_TX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_en  <= 1'b0;
      irq_en   <= 1'b0;
      clr_fire <= 1'b0;
    end else begin
      clr_fire <= ctrl_clr_wr;
      if (wr_ctrl) stat_en <= reg_wdata[0];
      if (wr_irq)  irq_en  <= reg_wdata[0];
    end
  end

  for (genvar i = 0; i < NUM_RX_CNT; i++) begin : g_rx
    logic [31:0] inc;
    if (i == RX_BYTE_IDX) begin : g_byte
      assign inc = 32'(rx_len);
    end else begin : g_one
      assign inc = 32'd1;
    end
    stat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(stat_en), .clr(clr_fire),
      .evt(rx_evt[i]), .inc(inc), .value(rx_val[i]), .wrap(rx_wrap[i]));
    assign all_cnt[i*CNT_W +: CNT_W] = rx_val[i];
  end

  for (genvar j = 0; j < NUM_TX_CNT; j++) begin : g_tx
    logic [31:0] inc;
    if (j == TX_BYTE_IDX) begin : g_byte
      assign inc = 32'(tx_len);
    end else begin : g_one
      assign inc = 32'd1;
    end
    stat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(stat_en), .clr(clr_fire),
      .evt(tx_evt[j]), .inc(inc), .value(tx_val[j]), .wrap(tx_wrap[j]));
    assign all_cnt[(NUM_RX_CNT+j)*CNT_W +: CNT_W] = tx_val[j];
  end

  carry_bank #(.N(NUM_RX_CNT)) u_carry_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr_fire), .set(rx_wrap),
    .w1c_en(wr_carry_rx), .mask_wr(wr_mask_rx), .wdata(reg_wdata),
    .carry(carry_rx), .mask(mask_rx), .pend(pend_rx));

  carry_bank #(.N(NUM_TX_CNT)) u_carry_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr_fire), .set(tx_wrap),
    .w1c_en(wr_carry_tx), .mask_wr(wr_mask_tx), .wdata(reg_wdata),
    .carry(carry_tx), .mask(mask_tx), .pend(pend_tx));

  assign ovf_irq = irq_en & (pend_rx | pend_tx);

  always_comb begin
    reg_rdata = 32'd0;
    unique case (reg_addr)
      ADDR_W'(REG_CTRL):     reg_rdata = {30'd0, clr_fire, stat_en};
      ADDR_W'(REG_IRQ):      reg_rdata = {31'd0, irq_en};
      ADDR_W'(REG_CARRY_RX): reg_rdata = carry_rx;
      ADDR_W'(REG_CARRY_TX): reg_rdata = carry_tx;
      ADDR_W'(REG_MASK_RX):  reg_rdata = mask_rx;
      ADDR_W'(REG_MASK_TX):  reg_rdata = mask_tx;
      default: begin
        for (int i = 0; i < NUM_RX_CNT; i++)
          if (reg_addr == ADDR_W'(CNT_BASE + i)) reg_rdata = 32'(rx_val[i]);
        for (int j = 0; j < NUM_TX_CNT; j++)
          if (reg_addr == ADDR_W'(CNT_BASE + NUM_RX_CNT + j)) reg_rdata = 32'(tx_val[j]);
      end
    endcase
  end
endmodule

// File: rtl/stats_bank_chk.sv
module stats_bank_chk #(
  parameter int NUM_RX_CNT = 21,
  parameter int NUM_TX_CNT = 8,
  parameter int CNT_W      = 32
) (
  input logic clk,
  input logic rst_n,
  input logic clr_fire,
  input logic ctrl_clr_wr,
  input logic stat_en,
  input logic irq_en,
  input logic ovf_irq,
  input logic wr_carry_rx,
  input logic wr_carry_tx,
  input logic [31:0] carry_rx,
  input logic [31:0] carry_tx,
  input logic [31:0] mask_rx,
  input logic [31:0] mask_tx,
  input logic [NUM_RX_CNT-1:0] rx_wrap,
  input logic [NUM_TX_CNT-1:0] tx_wrap,
  input logic [(NUM_RX_CNT+NUM_TX_CNT)*CNT_W-1:0] all_cnt
);
  logic [31:0] rx_wrap_pad, tx_wrap_pad;
  assign rx_wrap_pad = 32'(rx_wrap);
  assign tx_wrap_pad = 32'(tx_wrap);

  AST_CARRY_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_fire && !wr_carry_rx) |=> ((carry_rx & $past(carry_rx)) == $past(carry_rx))); // R1
  AST_CARRY_TX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_fire && !wr_carry_tx) |=> ((carry_tx & $past(carry_tx)) == $past(carry_tx))); // R1
  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mask_rx) && (&mask_tx)) |-> !ovf_irq); // R2
  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_en && !clr_fire) |=> $stable(all_cnt)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (all_cnt == '0 && carry_rx == 32'd0 && carry_tx == 32'd0)); // R4
  AST_CLR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && !ctrl_clr_wr) |=> !clr_fire); // R4
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !ovf_irq); // R5
  AST_WRAP_RX: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rx_wrap) && !clr_fire) |=> ((carry_rx & $past(rx_wrap_pad)) == $past(rx_wrap_pad))); // R9
  AST_WRAP_TX: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tx_wrap) && !clr_fire) |=> ((carry_tx & $past(tx_wrap_pad)) == $past(tx_wrap_pad))); // R7
endmodule

bind stats_bank stats_bank_chk #(
  .NUM_RX_CNT(NUM_RX_CNT), .NUM_TX_CNT(NUM_TX_CNT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_fire(clr_fire), .ctrl_clr_wr(ctrl_clr_wr),
  .stat_en(stat_en), .irq_en(irq_en), .ovf_irq(ovf_irq),
  .wr_carry_rx(wr_carry_rx), .wr_carry_tx(wr_carry_tx),
  .carry_rx(carry_rx), .carry_tx(carry_tx), .mask_rx(mask_rx), .mask_tx(mask_tx),
  .rx_wrap(rx_wrap), .tx_wrap(tx_wrap), .all_cnt(all_cnt)
);

// File: tb/tb_stats_bank.sv
`timescale 1ns/1ps
module tb_stats_bank;
  localparam int NRX = 21, NTX = 8, CW = 12, LW = 8, AW = 6;
  localparam int RXB = 7, TXB = 0, BASE = 16;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NRX-1:0] rx_evt = '0;
  logic [NTX-1:0] tx_evt = '0;
  logic [LW-1:0] rx_len = '0, tx_len = '0;
  logic ovf_irq;
  int checks = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stats_bank #(.NUM_RX_CNT(NRX), .NUM_TX_CNT(NTX), .CNT_W(CW), .LEN_W(LW),
               .RX_BYTE_IDX(RXB), .TX_BYTE_IDX(TXB), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_evt(rx_evt), .rx_len(rx_len),
    .tx_evt(tx_evt), .tx_len(tx_len), .ovf_irq(ovf_irq));

  typedef struct packed {
    logic [31:0] is_tx; logic [31:0] idx; logic [31:0] len;
    logic [31:0] n;     logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{0, 0, 0, 5, 5},
    '{0, RXB, 100, 3, 300},
    '{0, 20, 0, 1, 1},
    '{1, TXB, 255, 4, 1020},
    '{1, 7, 0, 9, 9},
    '{0, 12, 0, 2, 2},
    '{0, 3, 200, 2, 2}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] d);
    @(negedge clk); reg_addr = AW'(addr); reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(int addr, output logic [31:0] d);
    reg_addr = AW'(addr); #1; d = reg_rdata;
  endtask

  task automatic pulse(bit tx, int idx, int len, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_len = LW'(len); tx_len = LW'(len);
      if (tx) tx_evt = NTX'(1) << idx; else rx_evt = NRX'(1) << idx;
    end
    @(negedge clk); rx_evt = '0; tx_evt = '0;
  endtask

  task automatic clear_all();
    wr(0, 32'h3); @(negedge clk);
  endtask

  function automatic int cnt_addr(bit tx, int idx);
    return tx ? BASE + NRX + idx : BASE + idx;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    // R10 reset values
    rd(0, v); check("R10 ctrl", v, 0);
    rd(1, v); check("R10 irq en", v, 0);
    rd(2, v); check("R10 carry rx", v, 0);
    rd(3, v); check("R10 carry tx", v, 0);
    rd(4, v); check("R2 mask rx reset", v, 32'hFFFF_FFFF);
    rd(5, v); check("R2 mask tx reset", v, 32'hFFFF_FFFF);
    rd(BASE + RXB, v); check("R10 counter", v, 0);

    // R3: disabled counting leaves counters alone
    pulse(0, 0, 0, 4);
    rd(BASE, v); check("R3 disabled", v, 0);

    // R7 vector walk
    wr(0, 32'h1);
    foreach (VECS[i]) begin
      clear_all();
      pulse(VECS[i].is_tx[0], VECS[i].idx, VECS[i].len, VECS[i].n);
      rd(cnt_addr(VECS[i].is_tx[0], VECS[i].idx), v);
      check("R7 count", v, VECS[i].exp);
    end

    // R4 clear-all and self-clear
    pulse(0, 1, 0, 3);
    wr(0, 32'h3);
    rd(0, v); check("R4 clear bit visible", v, 32'h3);
    @(negedge clk);
    rd(0, v); check("R4 clear bit self-clears", v, 32'h1);
    rd(BASE + 1, v); check("R4 counter zeroed", v, 0);

    // R8 clear beats same-cycle event
    pulse(0, 0, 0, 3);
    wr(0, 32'h3);
    rx_evt = NRX'(1); @(negedge clk); rx_evt = '0;
    rd(BASE, v); check("R8 clear priority", v, 0);

    // R7 wrap on rx byte counter: 16*255=4080, 17th wraps to 239
    clear_all();
    pulse(0, RXB, 255, 16);
    rd(2, v); check("R7 no carry before wrap", v, 0);
    pulse(0, RXB, 255, 1);
    rd(BASE + RXB, v); check("R7 wrapped value", v, 239);
    rd(2, v); check("R7 carry rx bit", v, 32'h80);
    // R5, R2, R6
    #1; check("R5 irq off while disabled", {31'd0, ovf_irq}, 0);
    wr(1, 32'h1);
    #1; check("R2 masked carry quiet", {31'd0, ovf_irq}, 0);
    wr(4, ~32'h80);
    #1; check("R6 unmasked carry raises irq", {31'd0, ovf_irq}, 1);
    wr(1, 32'h0);
    #1; check("R5 enable cleared", {31'd0, ovf_irq}, 0);
    wr(1, 32'h1);
    // R1 W1C
    wr(2, 32'h0);
    rd(2, v); check("R1 write zero keeps", v, 32'h80);
    wr(2, 32'h80);
    rd(2, v); check("R1 write one clears", v, 0);
    #1; check("R6 irq drops", {31'd0, ovf_irq}, 0);

    // R7 tx wrap on plain counter 5
    clear_all();
    pulse(1, 5, 0, 4096);
    rd(cnt_addr(1, 5), v); check("R7 tx wrap value", v, 0);
    rd(3, v); check("R7 carry tx bit", v, 32'h20);
    wr(3, 32'h20);
    // R9: set and W1C in same cycle
    pulse(1, 5, 0, 4095);
    @(negedge clk);
    reg_addr = AW'(3); reg_wdata = 32'h20; reg_wr = 1; tx_evt = NTX'(1) << 5;
    @(negedge clk); reg_wr = 0; tx_evt = '0;
    rd(3, v); check("R9 set beats clear", v, 32'h20);
    // R4 clear removes carry too
    clear_all();
    rd(3, v); check("R4 carry cleared", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule